// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block keeps a direct-mapped table of recently resolved taken branches. Fetch presents an instruction address, the address-space identifier of the running context and the verdict of a separate direction predictor. In the same cycle the block reports whether it holds a target for that branch. It also gives the address fetch should use next: the stored target when both the direction predictor and the table agree on a taken branch, and the sequential address otherwise.

The table is filled from branch resolution. A resolved branch that was mispredicted and turned out to be taken writes its correct target into the slot picked by its address. Whatever that slot held before is replaced. The block does no direction prediction and no return-address tracking, and it has a single way.

Top module: `tagged_btb`

## Requirements
- R1: A synchronous reset clears every valid bit, so every lookup after reset misses until a new entry is written.
- R2: The two lowest address bits are dropped first. Slot index = address bits [13:2] (default depth 4096), and tag = address bits [29:14] (16 bits). Address bits [1:0] and [31:30] play no part in matching.
- R3: `lkHit` is 1 only when the indexed slot is valid, its stored tag equals the lookup tag, and its stored identifier equals `lkAsid`.
- R4: A slot is written only in a cycle with `updValid`=1, `updMispredict`=1 and `updTaken`=1. In any other update cycle the table does not change.
- R5: A write replaces the whole slot at its index (tag, identifier, target) and sets it valid, whatever the slot held before.
- R6: A lookup in the same cycle as a write to the same slot sees the old contents. The new contents are seen from the next cycle.
- R7: `predTaken` = `lkDirTaken` AND `lkHit`. `nextPc` is `lkTarget` when `predTaken` is 1, and `lkPc + 4` otherwise, including a taken verdict that misses.
- R8: On a hit, `lkTarget` returns the full 32-bit target stored by the most recent write to that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkPc | input | 32 | Lookup instruction address |
| lkAsid | input | 8 | Lookup address-space identifier |
| lkDirTaken | input | 1 | Direction predictor says taken |
| lkHit | output | 1 | Matching valid entry found |
| lkTarget | output | 32 | Target held in the indexed slot |
| predTaken | output | 1 | Final taken prediction |
| nextPc | output | 32 | Address fetch should use next |
| updValid | input | 1 | Resolution report present |
| updPc | input | 32 | Address of the resolved branch |
| updAsid | input | 8 | Identifier of the resolved branch |
| updMispredict | input | 1 | Resolved branch was mispredicted |
| updTaken | input | 1 | Resolved branch was actually taken |
| updTarget | input | 32 | Correct target of the resolved branch |

## Verification
The bench aims at aliasing. Two addresses one table-span apart share a slot, and a design that drops the tag compare would hit on the wrong one. A design that takes the wrong bit slice would miss on addresses that differ only in bits [1:0] or [31:30]. Identifier mismatches are tested the same way, since a missing identifier compare leaks targets across contexts. The bench sends update reports with only some of the three write conditions set and checks that the later lookup still misses, which catches a write enable that ignores one condition. It also checks the cycle of a write against a lookup of the same slot, where a write-through path would show the new target one cycle early. Finally, it predicts taken on a miss and expects the sequential address rather than a stale target.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // strobes from control to the table datapath
  typedef struct packed {
    logic wrEn;       // commit the resolution report into the table
    logic selTarget;  // steer fetch to the stored target
  } btbStrobe_t;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
(
  input  logic       updValid,
  input  logic       updMispredict,
  input  logic       updTaken,
  input  logic       lkDirTaken,
  input  logic       lkHit,
  output btbStrobe_t strobe
);
  // only a taken branch that was mispredicted teaches the table
  always_comb begin
    strobe.wrEn      = updValid & updMispredict & updTaken;
    strobe.selTarget = lkDirTaken & lkHit;
  end
endmodule

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ASID_W      = 8,
  parameter int TAG_W       = 16,
  parameter int DEPTH       = 4096,
  parameter int ALIGN_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  btbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] lkPc,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ASID_W-1:0] updAsid,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkTarget,
  output logic [ADDR_W-1:0] nextPc
);
  localparam int IDX_W      = $clog2(DEPTH);
  localparam int TAG_LSB    = ALIGN_SHIFT + IDX_W;
  localparam int TAG_MSB    = TAG_LSB + TAG_W - 1;
  localparam int INST_BYTES = 1 << ALIGN_SHIFT;

  logic [IDX_W-1:0]  lkIdx, updIdx;
  logic [TAG_W-1:0]  lkTag, updTag;
  logic [DEPTH-1:0]  validVec;
  logic [TAG_W-1:0]  tagMem  [DEPTH];
  logic [ASID_W-1:0] asidMem [DEPTH];
  logic [ADDR_W-1:0] tgtMem  [DEPTH];

  // split both addresses into slot index and partial tag
  assign lkIdx  = lkPc[ALIGN_SHIFT +: IDX_W];
  assign lkTag  = lkPc[TAG_LSB +: TAG_W];
  assign updIdx = updPc[ALIGN_SHIFT +: IDX_W];
  assign updTag = updPc[TAG_LSB +: TAG_W];

  // alignment and high bits of the update address never reach the table
  logic unusedUpdBits;
  generate
    if (TAG_MSB < ADDR_W - 1) begin : g_hiBits
      assign unusedUpdBits = ^{updPc[ALIGN_SHIFT-1:0], updPc[ADDR_W-1:TAG_MSB+1]};
    end else begin : g_noHiBits
      assign unusedUpdBits = ^updPc[ALIGN_SHIFT-1:0];
    end
  endgenerate

  // valid bits carry the reset; payload arrays are plain storage
  always_ff @(posedge clk) begin
    if (rst) validVec <= '0;
    else if (strobe.wrEn) validVec[updIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagMem[updIdx]  <= updTag;
      asidMem[updIdx] <= updAsid;
      tgtMem[updIdx]  <= updTarget;
    end
  end

  // read side is purely combinational, so a same-cycle write is not seen
  always_comb begin
    lkHit    = validVec[lkIdx] && (tagMem[lkIdx] == lkTag) && (asidMem[lkIdx] == lkAsid);
    lkTarget = tgtMem[lkIdx];
    nextPc   = strobe.selTarget ? lkTarget : lkPc + ADDR_W'(INST_BYTES);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (validVec == '0)); // R1

  AST_QUIET_TABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobe.wrEn)) |-> $stable(validVec)); // R4

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    strobe.wrEn |=> (validVec[$past(updIdx)] && tagMem[$past(updIdx)] == $past(updTag)
                     && asidMem[$past(updIdx)] == $past(updAsid)
                     && tgtMem[$past(updIdx)] == $past(updTarget))); // R5
endmodule

// File: rtl/tagged_btb.sv
module tagged_btb
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ASID_W      = 8,
  parameter int TAG_W       = 16,
  parameter int DEPTH       = 4096,
  parameter int ALIGN_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lkPc,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic              lkDirTaken,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkTarget,
  output logic              predTaken,
  output logic [ADDR_W-1:0] nextPc,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [ASID_W-1:0] updAsid,
  input  logic              updMispredict,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget
);
  localparam int INST_BYTES = 1 << ALIGN_SHIFT;

  btbStrobe_t strobe;

  btb_ctrl u_ctrl (
    .updValid      (updValid),
    .updMispredict (updMispredict),
    .updTaken      (updTaken),
    .lkDirTaken    (lkDirTaken),
    .lkHit         (lkHit),
    .strobe        (strobe)
  );

  btb_datapath #(
    .ADDR_W      (ADDR_W),
    .ASID_W      (ASID_W),
    .TAG_W       (TAG_W),
    .DEPTH       (DEPTH),
    .ALIGN_SHIFT (ALIGN_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .lkPc      (lkPc),
    .lkAsid    (lkAsid),
    .updPc     (updPc),
    .updAsid   (updAsid),
    .updTarget (updTarget),
    .lkHit     (lkHit),
    .lkTarget  (lkTarget),
    .nextPc    (nextPc)
  );

  assign predTaken = strobe.selTarget;

  AST_MISS_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    !lkHit |-> (!predTaken && nextPc == lkPc + ADDR_W'(INST_BYTES))); // R7

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    predTaken |-> (lkHit && lkDirTaken && nextPc == lkTarget)); // R7
endmodule

// File: tb/tb_tagged_btb.sv
module tb_tagged_btb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lkPc, updPc, updTarget;
  logic [7:0]  lkAsid, updAsid;
  logic        lkDirTaken, updValid, updMispredict, updTaken;
  logic        lkHit, predTaken;
  logic [31:0] lkTarget, nextPc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model: slot number -> contents
  bit          mValid [int];
  logic [15:0] mTag   [int];
  logic [7:0]  mAsid  [int];
  logic [31:0] mTgt   [int];

  always #4 clk = ~clk;

  tagged_btb dut (
    .clk(clk), .rst(rst), .lkPc(lkPc), .lkAsid(lkAsid), .lkDirTaken(lkDirTaken),
    .lkHit(lkHit), .lkTarget(lkTarget), .predTaken(predTaken), .nextPc(nextPc),
    .updValid(updValid), .updPc(updPc), .updAsid(updAsid),
    .updMispredict(updMispredict), .updTaken(updTaken), .updTarget(updTarget)
  );

  function automatic int slotOf(logic [31:0] a);
    return int'((a >> 2) % 4096);
  endfunction

  function automatic logic [15:0] tagOf(logic [31:0] a);
    return a[29:14];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare outputs against the model before the edge, then advance model
  task automatic cycle(string req);
    int s;
    bit eHit, eTaken;
    logic [31:0] eNext;
    #1;
    s = slotOf(lkPc);
    eHit = !rst && mValid.exists(s) && mValid[s] && mTag[s] == tagOf(lkPc) && mAsid[s] == lkAsid;
    eTaken = eHit && lkDirTaken;
    eNext = eTaken ? mTgt[s] : lkPc + 32'd4;
    if (!rst) begin
      check(req, "lkHit", {31'd0, lkHit}, {31'd0, eHit});
      check(req, "predTaken", {31'd0, predTaken}, {31'd0, eTaken});
      check(req, "nextPc", nextPc, eNext);
      if (eHit) check(req, "lkTarget", lkTarget, mTgt[s]);
    end
    @(posedge clk);
    if (rst) mValid.delete();
    else if (updValid && updMispredict && updTaken) begin
      s = slotOf(updPc);
      mValid[s] = 1'b1; mTag[s] = tagOf(updPc); mAsid[s] = updAsid; mTgt[s] = updTarget;
    end
    @(negedge clk);
  endtask

  task automatic idleUpd();
    updValid = 0; updMispredict = 0; updTaken = 0;
    updPc = '0; updAsid = '0; updTarget = '0;
  endtask

  task automatic look(logic [31:0] pc, logic [7:0] asid, logic dir, string req);
    idleUpd();
    lkPc = pc; lkAsid = asid; lkDirTaken = dir;
    cycle(req);
  endtask

  task automatic learn(logic [31:0] pc, logic [7:0] asid, logic [31:0] tgt,
                       logic v, logic mp, logic tk, string req);
    updValid = v; updMispredict = mp; updTaken = tk;
    updPc = pc; updAsid = asid; updTarget = tgt;
    lkPc = 32'h0000_0100; lkAsid = 8'h00; lkDirTaken = 0;
    cycle(req);
    idleUpd();
  endtask

  initial begin
    rst = 1; idleUpd();
    lkPc = '0; lkAsid = '0; lkDirTaken = 0;
    @(negedge clk); cycle("R1"); cycle("R1");
    rst = 0;
    // R1: nothing hits after reset
    look(32'h0000_1000, 8'h01, 1, "R1");
    look(32'h8000_0040, 8'h00, 1, "R1");

    // R3, R8, R7: basic learn then hit
    learn(32'h0000_1000, 8'h01, 32'hDEAD_BEE0, 1, 1, 1, "R4");
    look(32'h0000_1000, 8'h01, 1, "R8");
    look(32'h0000_1000, 8'h01, 0, "R7");
    look(32'h0000_1000, 8'h02, 1, "R3");
    // R2: one table-span apart aliases the slot but the tag differs
    look(32'h0000_1000 + 32'd16384, 8'h01, 1, "R2");
    look(32'h0000_1003, 8'h01, 1, "R2");
    look(32'h0000_1000 ^ 32'hC000_0000, 8'h01, 1, "R2");

    // R4: partial write conditions leave the table untouched
    learn(32'h0000_2000, 8'h03, 32'h1111_0000, 1, 1, 0, "R4");
    look(32'h0000_2000, 8'h03, 1, "R4");
    learn(32'h0000_2000, 8'h03, 32'h1111_0000, 1, 0, 1, "R4");
    look(32'h0000_2000, 8'h03, 1, "R4");
    learn(32'h0000_2000, 8'h03, 32'h1111_0000, 0, 1, 1, "R4");
    look(32'h0000_2000, 8'h03, 1, "R4");
    learn(32'h0000_1000, 8'h01, 32'h2222_0000, 1, 0, 1, "R4");
    look(32'h0000_1000, 8'h01, 1, "R4");

    // R5: aliasing write replaces the slot
    learn(32'h0000_1000 + 32'd16384, 8'h05, 32'h3333_3330, 1, 1, 1, "R5");
    look(32'h0000_1000, 8'h01, 1, "R5");
    look(32'h0000_1000 + 32'd16384, 8'h05, 1, "R5");

    // R6: write and lookup of the same slot in one cycle
    updValid = 1; updMispredict = 1; updTaken = 1;
    updPc = 32'h0000_1000 + 32'd16384; updAsid = 8'h05; updTarget = 32'h4444_4440;
    lkPc = updPc; lkAsid = 8'h05; lkDirTaken = 1;
    cycle("R6");
    look(32'h0000_1000 + 32'd16384, 8'h05, 1, "R6");

    // R1: reset again wipes learned entries
    rst = 1; cycle("R1"); rst = 0;
    look(32'h0000_1000 + 32'd16384, 8'h05, 1, "R1");

    // mixed traffic over a small address pool to force hits and aliasing
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = {$urandom_range(3), 16'd0, 2'd0, 12'($urandom_range(7)), 2'($urandom_range(3))};
      b = {$urandom_range(3), 16'd0, 2'd0, 12'($urandom_range(7)), 2'd0};
      lkPc = a; lkAsid = 8'($urandom_range(1)); lkDirTaken = 1'($urandom_range(1));
      updValid = 1'($urandom_range(1)); updMispredict = 1'($urandom_range(1));
      updTaken = 1'($urandom_range(1)); updPc = b;
      updAsid = 8'($urandom_range(1)); updTarget = $urandom;
      cycle("R7");
    end
    idleUpd();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule